// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a heartbeat line driven by a processor and pulls an active-low fault output low when the line has not changed level for a programmable number of timebase ticks. A rising change and a falling change both count as a kick. Each kick restarts the timing window. A kick also clears a fault that has already been raised.

The heartbeat line may come from any clock domain. It passes through a two-stage synchronizer, and a change of level between two successive synchronized samples forms a one-cycle kick. A prescaler divides the system clock by `PRESCALE` to form a tick. An 8-bit counter counts these ticks up to the programmed period value. When the counter reaches the period, the fault output drops and stays low. It leaves that state only through a kick or a system reset.

The system reset from the supervisor is active low and holds the whole block disabled. While reset is active the fault output is high. When reset is released, timing starts again from zero.

Top module: `edge_wdt`

## Requirements
- R1: While `rst_n` is low, `wdt_n` is high, whatever the heartbeat input and the period input do.
- R2: With no kick and a stable `period` of N, `wdt_n` goes low on the (N*PRESCALE+1)-th rising clock edge after the window start. The window starts at reset release: the first edge with `rst_n` high counts as edge 1. A window also starts on the edge where a kick takes effect.
- R3: Once `wdt_n` is low, it stays low for as long as no kick arrives and `rst_n` stays high.
- R4: A low-to-high change and a high-to-low change of `hb_in` each count as a kick. A kick takes effect on the third rising clock edge after the change, because the line first passes two synchronizer flops.
- R5: A kick that arrives while `wdt_n` is low drives `wdt_n` high on the edge where the kick takes effect. It also starts a new full window, so `wdt_n` falls again after N*PRESCALE+1 further edges if no further kick arrives.
- R6: Kicks that arrive before the window ends keep `wdt_n` high, and each kick restarts the window from zero.
- R7: When a kick takes effect on the same edge on which the timeout would drive `wdt_n` low, the kick wins. `wdt_n` stays high and a new window starts.
- R8: A `period` of 0 drives `wdt_n` low on the first edge of the window.
- R9: Releasing `rst_n` starts a fresh window from a zero count, even if a fault was latched when reset was applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset from the supervisor. It resets asynchronously and holds the watchdog disabled. |
| hb_in | input | 1 | Asynchronous heartbeat line. Either change of level is a kick. |
| period | input | CNT_W | Timeout length in prescaled ticks |
| wdt_n | output | 1 | Active-low watchdog fault, latched until a kick or a reset |

## Verification
The properties take for granted that `period` does not change while a window is running. The bench changes it only while reset is applied, or just after a kick has restarted the count. The properties also assume that `hb_in` holds each level for at least two clock cycles, so that no change is lost in the synchronizer. The bench drives the heartbeat only on falling clock edges and holds every level for three or more cycles. It keeps `hb_in` low whenever reset is released, so no change is left pending when the window starts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Three taps of the heartbeat synchronizer: two metastability flops
    // plus the previous synchronized sample used for change detection.
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } hb_sync_t;

    localparam int unsigned DEF_CNT_W    = 8;
    localparam int unsigned DEF_PRESCALE = 16;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic change_o
);
    hb_sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign change_o = st_q.sync ^ st_q.prev;
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int unsigned PRESCALE = wdt_pkg::DEF_PRESCALE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick_o
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick_o = 1'b1;
        end else begin : g_div
            logic [PRE_W-1:0] pre_d, pre_q;
            logic             wrap;

            assign wrap = (pre_q == PRE_LAST);

            always_comb begin
                pre_d = pre_q;
                if (clear)     pre_d = '0;
                else if (wrap) pre_d = '0;
                else           pre_d = pre_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick_o = wrap;
        end
    endgenerate
endmodule

// File: rtl/wdt_timeout_core.sv
module wdt_timeout_core #(
    parameter int unsigned CNT_W = wdt_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fault_n_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flt_n;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     expired;

    // Count at or beyond the period: stop counting, raise the fault.
    assign expired = (st_q.cnt >= period);

    always_comb begin
        st_d = st_q;
        if (kick) begin
            // A kick beats a simultaneous timeout.
            st_d.cnt   = '0;
            st_d.flt_n = 1'b1;
        end else begin
            if (tick && !expired) st_d.cnt = st_q.cnt + 1'b1;
            if (expired)          st_d.flt_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.flt_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign fault_n_o = st_q.flt_n;
endmodule

// File: rtl/edge_wdt.sv
module edge_wdt #(
    parameter int unsigned CNT_W    = wdt_pkg::DEF_CNT_W,
    parameter int unsigned PRESCALE = wdt_pkg::DEF_PRESCALE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_in,
    input  logic [CNT_W-1:0] period,
    output logic             wdt_n
);
    logic             kick;
    logic             tick;
    logic [CNT_W-1:0] cnt_val;

    wdt_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hb_in),
        .change_o (kick)
    );

    wdt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (kick),
        .tick_o (tick)
    );

    wdt_timeout_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (kick),
        .tick      (tick),
        .period    (period),
        .cnt_o     (cnt_val),
        .fault_n_o (wdt_n)
    );
endmodule

// File: rtl/edge_wdt_chk.sv
module edge_wdt_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period,
    input logic             wdt_n
);
    // R3
    fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_n && !kick) |=> !wdt_n);

    // R5
    kick_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> wdt_n);

    // R6
    kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0));

    // R2
    fall_after_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_n) |-> $past(cnt >= period));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(period) && (cnt <= period)) |=> (cnt <= period));
endmodule

bind edge_wdt edge_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (kick),
    .cnt    (cnt_val),
    .period (period),
    .wdt_n  (wdt_n)
);

// File: tb/sim_edge_wdt.sv
`timescale 1ns/1ps
module sim_edge_wdt;
    localparam int unsigned CW  = 8;
    localparam int unsigned PS  = 4;
    localparam int unsigned N   = 5;
    localparam int unsigned WIN = N * PS;   // edges before the count is full

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hb_in = 1'b0;
    logic [CW-1:0] period = CW'(N);
    logic          wdt_n;

    int checks = 0;
    int fails  = 0;

    edge_wdt #(.CNT_W(CW), .PRESCALE(PS)) u0 (
        .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .period(period), .wdt_n(wdt_n)
    );

    always #5 clk = ~clk;

    task automatic check(input bit exp, input string tag);
        checks++;
        if (wdt_n !== exp) begin
            fails++;
            $display("FAIL %s: wdt_n actual %b expected %b at %0t", tag, wdt_n, exp, $time);
        end
    endtask

    // Wait for n rising edges, then settle at the next falling edge.
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Toggle the heartbeat and stop at the falling edge after the edge where it takes effect.
    task automatic kick();
        hb_in = ~hb_in;
        edges(3);
    endtask

    // Apply reset with heartbeat activity, check the output, release with hb low.
    task automatic do_reset(input int unsigned per);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            hb_in = ~hb_in;
            period = CW'(i);
            edges(1);
            check(1'b1, "R1 output high during reset");
        end
        hb_in  = 1'b0;
        period = CW'(per);
        edges(2);
        rst_n = 1'b1;
    endtask

    task automatic t_timeout();
        do_reset(N);
        edges(WIN);
        check(1'b1, "R2 high on last edge of window");
        edges(1);
        check(1'b0, "R2 low one edge after window");
        edges(40);
        check(1'b0, "R3 stays latched low");
    endtask

    task automatic t_clear_rise();
        // Fault is latched here; hb is low, so this is a rising change.
        hb_in = 1'b1;
        edges(2);
        check(1'b0, "R4 still low two edges after rising change");
        edges(1);
        check(1'b1, "R4 R5 rising kick clears fault on third edge");
        edges(WIN);
        check(1'b1, "R5 full window after clear");
        edges(1);
        check(1'b0, "R5 timeout again after clearing kick");
    endtask

    task automatic t_clear_fall();
        hb_in = 1'b0;
        edges(2);
        check(1'b0, "R4 still low two edges after falling change");
        edges(1);
        check(1'b1, "R4 falling kick clears fault");
    endtask

    task automatic t_keepalive();
        do_reset(N);
        for (int k = 0; k < 8; k++) begin
            edges(WIN - 6);
            kick();
            check(1'b1, "R6 periodic kicks keep output high");
        end
        edges(WIN);
        check(1'b1, "R6 window restarted by last kick");
        edges(1);
        check(1'b0, "R6 timeout after kicks stop");
    endtask

    task automatic t_priority();
        do_reset(N);
        edges(WIN - 2);
        kick();                       // takes effect on edge WIN+1
        check(1'b1, "R7 kick beats coincident timeout");
        edges(WIN);
        check(1'b1, "R7 new window after coincident kick");
        edges(1);
        check(1'b0, "R7 timeout of the following window");
    endtask

    task automatic t_zero_period();
        do_reset(0);
        check(1'b1, "R8 high before first edge");
        edges(1);
        check(1'b0, "R8 zero period faults on first edge");
    endtask

    task automatic t_reset_restart();
        // Fault latched from previous task; reset must clear it and restart.
        do_reset(3);
        check(1'b1, "R9 high after release despite earlier fault");
        edges(3 * PS);
        check(1'b1, "R9 window counted from zero");
        edges(1);
        check(1'b0, "R9 timeout of the fresh window");
    endtask

    initial begin
        edges(1);
        check(1'b1, "R1 output high at reset");
        t_timeout();
        t_clear_rise();
        t_clear_fall();
        t_keepalive();
        t_priority();
        t_zero_period();
        t_reset_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule